// File: doc/BRIEF.md
# Immediate Prefix Extension Merger

This decode-stage block collects up to two immediate-extension prefix words that come before a load, store or move instruction. When the instruction itself arrives, the block joins the stored prefix payloads with the instruction's own 7-bit field. The result is one widened immediate: a base offset, an auto-modify step, an absolute or stack-relative address offset, or a data constant. Which it is depends on the instruction's form code.

The fetch stream arrives as a word-valid strobe, a decoded "this word is a prefix" flag and a 13-bit prefix payload. Each instruction word also comes with its decoded form code, its 7-bit field and an access-size flag. The merged immediate is combinational in the instruction's cycle. The stored prefixes are cleared on the next clock edge, so the next instruction starts clean. Reset and a pipeline flush also discard them. Memory access, address addition and register writeback belong to later stages.

Top module: `pxm_prefix_merger`

## Requirements
- R1: After reset, and on the clock edge after `flush` is high, `pfx_cnt` is 0 and any stored payloads are discarded. A prefix that arrives in the same cycle as `flush` is not kept.
- R2: A word with `word_vld` and `word_is_pfx` both high stores its payload and raises `pfx_cnt` by one, up to a maximum of 2. A third consecutive prefix drops the oldest payload and keeps the two newest. `word_is_pfx` has no effect while `word_vld` is low.
- R3: A valid non-prefix word uses the stored prefixes, and `pfx_cnt` is 0 on the following edge.
- R4: Register-base offset form (form code 1): 0 with no prefix. With one prefix it is the 13-bit payload, zero-extended. With two it is the older payload's bits [10:0] above the newer 13-bit payload, 24 bits in all.
- R5: Absolute form (code 3) and stack-relative form (code 4): the field zero-extended with no prefix. With one prefix it is {payload, field}, 20 bits, zero-extended. With two it is {older[3:0], newer, field}, 24 bits.
- R6: Data form (code 5): with no prefix the 7-bit field is sign-extended to 16 bits, and bits [23:16] are 0. With one prefix it is {payload[8:0], field}, a 16-bit value with bits [23:16] 0. With two it is built as in R5.
- R7: Auto-modify step form (code 2): with no prefix the step is 1 for a byte access and 2 when `wide_acc` is high. With prefixes the step is built as in R4.
- R8: Register move form (code 0): `imm_val` is 0. `dual_cycle` is high only for a valid move that has at least one stored prefix, and shows a 2-cycle move.
- R9: `imm_vld` is high exactly when `word_vld` is high, `word_is_pfx` is low and `flush` is low.
- R10: The unused form codes 6 and 7 give `imm_val` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush, discards stored prefixes |
| word_vld | input | 1 | A fetched word is present this cycle |
| word_is_pfx | input | 1 | The present word is an extension prefix |
| pfx_payload | input | 13 | Immediate bits carried by a prefix word |
| form_code | input | 3 | Decoded instruction form (0 move, 1 base offset, 2 step, 3 absolute, 4 stack-relative, 5 data) |
| fld7 | input | 7 | The instruction's own 7-bit immediate field |
| wide_acc | input | 1 | Access is 16-bit (affects the default step) |
| imm_vld | output | 1 | Merged immediate is valid this cycle |
| imm_val | output | 24 | Merged immediate |
| pfx_cnt | output | 2 | Number of prefixes held (0 to 2) |
| dual_cycle | output | 1 | Register move takes 2 cycles |

## Verification
The hardest situation to reach from the ports is eviction. A third prefix has to push out the oldest payload while the count stays at 2, and the merged value then has to show that the right two payloads survived. The stimulus sends three prefixes with distinct payloads and then an absolute-form instruction. The expected value is built only from the second and third payloads, so a wrong slot order or a count that does not saturate shows up in the result. Flush that coincides with a prefix, and flush that coincides with an instruction, are driven as separate sequences.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int WORD_W  = 16;
  localparam int PFX_W   = 13;
  localparam int FLD_W   = 7;
  localparam int IMM_W   = 24;
  localparam int DATA_W  = 16;
  localparam int MAX_PFX = 2;
  localparam int CNT_W   = $clog2(MAX_PFX + 1);
  localparam int FORM_W  = 3;
  localparam int OFS_HI_W = IMM_W - PFX_W;          // older bits kept for offsets
  localparam int ADR_HI_W = IMM_W - PFX_W - FLD_W;  // older bits kept for addresses
  localparam int ONE_W    = PFX_W + FLD_W;          // one-prefix address width
  localparam int DAT_PW   = DATA_W - FLD_W;         // payload bits in data form

  typedef enum logic [FORM_W-1:0] {
    FM_REGMOV = 3'd0,
    FM_RBOFS  = 3'd1,
    FM_RBSTEP = 3'd2,
    FM_ABS    = 3'd3,
    FM_SPOFS  = 3'd4,
    FM_DATA7  = 3'd5
  } form_e;

  function automatic logic [IMM_W-1:0] fn_offset(input logic [CNT_W-1:0] n,
      input logic [PFX_W-1:0] older, input logic [PFX_W-1:0] newer);
    logic [IMM_W-1:0] r;
    case (n)
      CNT_W'(0): r = '0;
      CNT_W'(1): r = {{OFS_HI_W{1'b0}}, newer};
      default:   r = {older[OFS_HI_W-1:0], newer};
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] fn_address(input logic [CNT_W-1:0] n,
      input logic [PFX_W-1:0] older, input logic [PFX_W-1:0] newer,
      input logic [FLD_W-1:0] fld);
    logic [IMM_W-1:0] r;
    case (n)
      CNT_W'(0): r = {{(IMM_W-FLD_W){1'b0}}, fld};
      CNT_W'(1): r = {{(IMM_W-ONE_W){1'b0}}, newer, fld};
      default:   r = {older[ADR_HI_W-1:0], newer, fld};
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] fn_data(input logic [CNT_W-1:0] n,
      input logic [PFX_W-1:0] older, input logic [PFX_W-1:0] newer,
      input logic [FLD_W-1:0] fld);
    logic [IMM_W-1:0] r;
    case (n)
      CNT_W'(0): r = {{(IMM_W-DATA_W){1'b0}}, {(DATA_W-FLD_W){fld[FLD_W-1]}}, fld};
      CNT_W'(1): r = {{(IMM_W-DATA_W){1'b0}}, newer[DAT_PW-1:0], fld};
      default:   r = fn_address(n, older, newer, fld);
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] fn_step(input logic [CNT_W-1:0] n,
      input logic [PFX_W-1:0] older, input logic [PFX_W-1:0] newer,
      input logic wide);
    logic [IMM_W-1:0] r;
    if (n == CNT_W'(0)) r = wide ? IMM_W'(2) : IMM_W'(1);
    else                r = fn_offset(n, older, newer);
    return r;
  endfunction
endpackage

// File: rtl/pxm_slot_store.sv
module pxm_slot_store
  import pxm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             consume,
  input  logic [PFX_W-1:0] payload,
  output logic [CNT_W-1:0] cnt,
  output logic [PFX_W-1:0] older,
  output logic [PFX_W-1:0] newer,
  output logic             evict
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PFX);

  assign evict = push && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      older <= '0;
      newer <= '0;
    end else if (clr) begin
      cnt   <= '0;
      older <= '0;
      newer <= '0;
    end else if (push) begin
      older <= newer;
      newer <= payload;
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end else if (consume) begin
      cnt   <= '0;
      older <= '0;
      newer <= '0;
    end
  end
endmodule

// File: rtl/pxm_imm_merge.sv
module pxm_imm_merge
  import pxm_pkg::*;
(
  input  logic [FORM_W-1:0] form_code,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PFX_W-1:0]  older,
  input  logic [PFX_W-1:0]  newer,
  input  logic [FLD_W-1:0]  fld,
  input  logic              wide,
  output logic [IMM_W-1:0]  imm
);
  always_comb begin
    case (form_code)
      FM_RBOFS:          imm = fn_offset(cnt, older, newer);
      FM_RBSTEP:         imm = fn_step(cnt, older, newer, wide);
      FM_ABS, FM_SPOFS:  imm = fn_address(cnt, older, newer, fld);
      FM_DATA7:          imm = fn_data(cnt, older, newer, fld);
      default:           imm = '0;
    endcase
  end
endmodule

// File: rtl/pxm_cycle_est.sv
module pxm_cycle_est
  import pxm_pkg::*;
(
  input  logic              instr,
  input  logic [FORM_W-1:0] form_code,
  input  logic [CNT_W-1:0]  cnt,
  output logic              dual
);
  assign dual = instr && (form_code == FM_REGMOV) && (cnt != CNT_W'(0));
endmodule

// File: rtl/pxm_prefix_merger.sv
module pxm_prefix_merger
  import pxm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              word_vld,
  input  logic              word_is_pfx,
  input  logic [PFX_W-1:0]  pfx_payload,
  input  logic [FORM_W-1:0] form_code,
  input  logic [FLD_W-1:0]  fld7,
  input  logic              wide_acc,
  output logic              imm_vld,
  output logic [IMM_W-1:0]  imm_val,
  output logic [CNT_W-1:0]  pfx_cnt,
  output logic              dual_cycle
);
  // named events for the checker
  logic             ev_push;
  logic             ev_consume;
  logic             ev_evict;
  logic [PFX_W-1:0] slot_old;
  logic [PFX_W-1:0] slot_new;
  logic [IMM_W-1:0] merged;

  assign ev_push    = word_vld && word_is_pfx;
  assign ev_consume = word_vld && !word_is_pfx;

  pxm_slot_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .push    (ev_push),
    .consume (ev_consume),
    .payload (pfx_payload),
    .cnt     (pfx_cnt),
    .older   (slot_old),
    .newer   (slot_new),
    .evict   (ev_evict)
  );

  pxm_imm_merge u_merge (
    .form_code (form_code),
    .cnt       (pfx_cnt),
    .older     (slot_old),
    .newer     (slot_new),
    .fld       (fld7),
    .wide      (wide_acc),
    .imm       (merged)
  );

  pxm_cycle_est u_cyc (
    .instr     (imm_vld),
    .form_code (form_code),
    .cnt       (pfx_cnt),
    .dual      (dual_cycle)
  );

  assign imm_vld = ev_consume && !flush;
  assign imm_val = merged;
endmodule

// File: rtl/pxm_prefix_merger_chk.sv
module pxm_prefix_merger_chk
  import pxm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ev_push,
  input logic              ev_evict,
  input logic              imm_vld,
  input logic [IMM_W-1:0]  imm_val,
  input logic [CNT_W-1:0]  pfx_cnt,
  input logic [FORM_W-1:0] form_code,
  input logic [FLD_W-1:0]  fld7,
  input logic              wide_acc,
  input logic              dual_cycle
);
  p_cnt_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt <= CNT_W'(MAX_PFX));

  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push && !flush && (pfx_cnt < CNT_W'(MAX_PFX)) |=> pfx_cnt == $past(pfx_cnt) + CNT_W'(1));

  p_push_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict && !flush |=> pfx_cnt == CNT_W'(MAX_PFX));

  p_consume_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imm_vld |=> pfx_cnt == '0);

  p_flush_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> pfx_cnt == '0);

  p_flush_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !imm_vld);

  p_dual_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dual_cycle |-> imm_vld && form_code == FM_REGMOV && pfx_cnt != '0);

  p_rb_bare_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imm_vld && form_code == FM_RBOFS && pfx_cnt == '0 |-> imm_val == '0);

  p_abs_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imm_vld && form_code == FM_ABS && pfx_cnt == CNT_W'(1)
      |-> imm_val[IMM_W-1:ONE_W] == '0 && imm_val[FLD_W-1:0] == fld7);

  p_data_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    imm_vld && form_code == FM_DATA7 && pfx_cnt != CNT_W'(2) |-> imm_val[IMM_W-1:DATA_W] == '0);

  p_step_bare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    imm_vld && form_code == FM_RBSTEP && pfx_cnt == '0
      |-> imm_val == (wide_acc ? IMM_W'(2) : IMM_W'(1)));
endmodule

bind pxm_prefix_merger pxm_prefix_merger_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .ev_push    (ev_push),
  .ev_evict   (ev_evict),
  .imm_vld    (imm_vld),
  .imm_val    (imm_val),
  .pfx_cnt    (pfx_cnt),
  .form_code  (form_code),
  .fld7       (fld7),
  .wide_acc   (wide_acc),
  .dual_cycle (dual_cycle)
);

// File: tb/test_pxm_prefix_merger.sv
`timescale 1ns/100ps
module test_pxm_prefix_merger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        word_vld = 1'b0;
  logic        word_is_pfx = 1'b0;
  logic [12:0] pfx_payload = '0;
  logic [2:0]  form_code = '0;
  logic [6:0]  fld7 = '0;
  logic        wide_acc = 1'b0;
  logic        imm_vld;
  logic [23:0] imm_val;
  logic [1:0]  pfx_cnt;
  logic        dual_cycle;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pxm_prefix_merger i_pxm_prefix_merger (
    .clk(clk), .rst_n(rst_n), .flush(flush), .word_vld(word_vld),
    .word_is_pfx(word_is_pfx), .pfx_payload(pfx_payload), .form_code(form_code),
    .fld7(fld7), .wide_acc(wide_acc), .imm_vld(imm_vld), .imm_val(imm_val),
    .pfx_cnt(pfx_cnt), .dual_cycle(dual_cycle)
  );

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // independent arithmetic model of the requirements
  function automatic int unsigned model(input int f, input int n, input int unsigned o,
                                        input int unsigned w, input int unsigned d, input bit wa);
    case (f)
      1, 2: begin
        if (n == 0) return (f == 2) ? (wa ? 2 : 1) : 0;
        if (n == 1) return w;
        return (o % 2048) * 8192 + w;
      end
      3, 4: begin
        if (n == 0) return d;
        if (n == 1) return w * 128 + d;
        return (o % 16) * 1048576 + w * 128 + d;
      end
      5: begin
        if (n == 0) return (d >= 64) ? d + 32'hFF80 : d;
        if (n == 1) return (w % 512) * 128 + d;
        return (o % 16) * 1048576 + w * 128 + d;
      end
      default: return 0;
    endcase
  endfunction

  task automatic pfx(input int unsigned p);
    @(negedge clk);
    word_vld = 1'b1; word_is_pfx = 1'b1; pfx_payload = 13'(p);
    @(negedge clk);
    word_vld = 1'b0; word_is_pfx = 1'b0;
  endtask

  task automatic ins(input string tag, input int f, input int unsigned d, input bit wa,
                     input int n, input int unsigned o, input int unsigned w);
    @(negedge clk);
    word_vld = 1'b1; word_is_pfx = 1'b0; form_code = 3'(f); fld7 = 7'(d); wide_acc = wa;
    #1;
    chk({tag, " R9 vld"}, imm_vld, 1);
    chk({tag, " imm"}, imm_val, model(f, n, o, w, d, wa));
    chk({tag, " R8 dual"}, dual_cycle, (f == 0 && n > 0) ? 1 : 0);
    @(negedge clk);
    word_vld = 1'b0;
    #1;
    chk({tag, " R3 cnt cleared"}, pfx_cnt, 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset cnt", pfx_cnt, 0);
    chk("R9 reset vld", imm_vld, 0);
    chk("R8 reset dual", dual_cycle, 0);
  endtask

  task automatic t_rb;
    ins("R4 rb n0", 1, 7'h55, 0, 0, 0, 0);
    pfx(13'h1ABC); chk("R2 cnt one", pfx_cnt, 1);
    ins("R4 rb n1", 1, 7'h11, 0, 1, 0, 13'h1ABC);
    pfx(13'h0F0F); pfx(13'h1234); chk("R2 cnt two", pfx_cnt, 2);
    ins("R4 rb n2", 1, 7'h11, 0, 2, 13'h0F0F, 13'h1234);
  endtask

  task automatic t_step;
    ins("R7 step byte", 2, 7'h7F, 0, 0, 0, 0);
    ins("R7 step word", 2, 7'h7F, 1, 0, 0, 0);
    pfx(13'h0040);
    ins("R7 step n1", 2, 7'h01, 1, 1, 0, 13'h0040);
    pfx(13'h1FFF); pfx(13'h0003);
    ins("R7 step n2", 2, 7'h01, 0, 2, 13'h1FFF, 13'h0003);
  endtask

  task automatic t_addr;
    ins("R5 abs n0", 3, 7'h6A, 0, 0, 0, 0);
    pfx(13'h1555);
    ins("R5 abs n1", 3, 7'h2B, 0, 1, 0, 13'h1555);
    pfx(13'h000A); pfx(13'h0ACE);
    ins("R5 sp n2", 4, 7'h7E, 0, 2, 13'h000A, 13'h0ACE);
    pfx(13'h1001);
    ins("R5 sp n1", 4, 7'h00, 0, 1, 0, 13'h1001);
  endtask

  task automatic t_data;
    ins("R6 data neg", 5, 7'h41, 0, 0, 0, 0);
    ins("R6 data pos", 5, 7'h3F, 0, 0, 0, 0);
    pfx(13'h1F7D);
    ins("R6 data n1", 5, 7'h70, 0, 1, 0, 13'h1F7D);
    pfx(13'h0007); pfx(13'h0101);
    ins("R6 data n2", 5, 7'h05, 0, 2, 13'h0007, 13'h0101);
  endtask

  task automatic t_regmov;
    ins("R8 mov n0", 0, 7'h33, 0, 0, 0, 0);
    pfx(13'h0999);
    ins("R8 mov n1", 0, 7'h33, 0, 1, 0, 13'h0999);
  endtask

  task automatic t_evict;
    pfx(13'h0111); pfx(13'h0225); pfx(13'h0B3C);
    chk("R2 cnt saturated", pfx_cnt, 2);
    ins("R2 evict abs", 3, 7'h19, 0, 2, 13'h0225, 13'h0B3C);
  endtask

  task automatic t_idle;
    pfx(13'h0042);
    @(negedge clk);
    word_vld = 1'b0; word_is_pfx = 1'b1; pfx_payload = 13'h1EEE;
    @(negedge clk);
    word_is_pfx = 1'b0;
    #1;
    chk("R2 idle prefix ignored cnt", pfx_cnt, 1);
    ins("R2 idle prefix ignored imm", 1, 7'h00, 0, 1, 0, 13'h0042);
  endtask

  task automatic t_flush;
    pfx(13'h0777); pfx(13'h0888);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    #1;
    chk("R1 flush clears cnt", pfx_cnt, 0);
    ins("R1 after flush abs", 3, 7'h12, 0, 0, 0, 0);
    pfx(13'h0555);
    @(negedge clk);
    flush = 1'b1; word_vld = 1'b1; word_is_pfx = 1'b0; form_code = 3'd3;
    #1;
    chk("R9 flush mutes vld", imm_vld, 0);
    @(negedge clk);
    flush = 1'b0; word_vld = 1'b0;
    #1;
    chk("R1 flush with instr cnt", pfx_cnt, 0);
    @(negedge clk);
    flush = 1'b1; word_vld = 1'b1; word_is_pfx = 1'b1; pfx_payload = 13'h0ABC;
    @(negedge clk);
    flush = 1'b0; word_vld = 1'b0; word_is_pfx = 1'b0;
    #1;
    chk("R1 prefix with flush dropped", pfx_cnt, 0);
  endtask

  task automatic t_unknown;
    pfx(13'h1234);
    ins("R10 code6", 6, 7'h7F, 1, 1, 0, 13'h1234);
    ins("R10 code7", 7, 7'h7F, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_rb();
    t_step();
    t_addr();
    t_data();
    t_regmov();
    t_evict();
    t_idle();
    t_flush();
    t_unknown();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule